// File: doc/BRIEF.md
# Half-Bridge Gate Interlock and Fault Shutdown Controller

This block turns two logic-level switching commands into the gate enables of one half-bridge leg. The upper-switch command is active high; the lower-switch command is active low. Both commands are resynchronised to the block clock. The block then decodes them into a requested side. A request for both sides at once is treated as a conflict, and so is a request for neither; in both cases the leg is left fully off. Whenever conduction moves from one side to the other, the block holds both switches off for a programmable number of clock cycles before the new side is turned on.

A second path handles faults. A synchronised over-current flag removes both gate enables in the same clock cycle, through logic only, without waiting for any register. On the following clock edge the block engages an open-drain pull-down on the external shutdown line and keeps it engaged until the line is reported below its lower input threshold. After the release, the leg stays off until the line is reported above its upper threshold; normal operation then resumes. Independently, an externally driven low shutdown line forces the leg off for as long as it is low.

Top module: `hb_gate_ctrl`

## Requirements
- R1: The upper gate enable `gate_hi` follows `cmd_hi` = 1 together with `cmd_lo_n` = 1, and the lower gate enable `gate_lo` follows `cmd_hi` = 0 together with `cmd_lo_n` = 0. Both gate enables are active high. A command change first shows at the outputs on the third rising clock edge after it, because of two synchroniser stages plus the drive register.
- R2: While `sd_below` = 1 (shutdown line under its lower threshold), both gate enables are 0 in that same cycle, whatever the commands are.
- R3: When both commands ask for conduction (`cmd_hi` = 1, `cmd_lo_n` = 0), both gate enables are 0.
- R4: When neither command asks for conduction (`cmd_hi` = 0, `cmd_lo_n` = 1), both gate enables are 0.
- R5: At every handover, both gate enables stay 0 for max(N, `dead_cycles` + 1) cycles. N is the number of cycles between the synchronised request leaving the old side and reaching the new side. This covers simultaneous edges (N = 0), overlapping edges, second edges that arrive inside the dead time, and edges separated by more than the dead time. A `dead_cycles` value of 0 still gives one off cycle, and the largest value, 1023, gives 1024.
- R6: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R7: `fault` = 1 forces both gate enables to 0 within the same cycle.
- R8: `pull_dn` rises on the clock edge after `fault` is sampled high. It stays 1 while `sd_below` = 0. It falls on the clock edge after `sd_below` is sampled high.
- R9: After `pull_dn` is released, both gate enables stay 0 until `sd_above` is sampled high. The requested side is then enabled on the second clock edge after that sample, provided the dead time has elapsed.
- R10: While `rst_n` = 0, `gate_hi`, `gate_lo` and `pull_dn` are all 0. The first turn-on after reset still waits out the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi | input | 1 | Upper-switch command, active high, asynchronous |
| cmd_lo_n | input | 1 | Lower-switch command, active low, asynchronous |
| fault | input | 1 | Synchronised over-current comparator flag, active high |
| sd_below | input | 1 | Shutdown line is under its lower input threshold |
| sd_above | input | 1 | Shutdown line is over its upper input threshold |
| dead_cycles | input | 10 | Dead time count; off interval is this value plus one cycles |
| gate_hi | output | 1 | Upper gate enable, active high |
| gate_lo | output | 1 | Lower gate enable, active high |
| pull_dn | output | 1 | Open-drain pull-down enable for the shutdown line |

## Verification
A drive register or dead-time counter holding a wrong value shows up at the gate enables. It appears either as a handover gap that differs from max(N, `dead_cycles` + 1), or as both enables high together, on the first handover after the corruption. A wrong fault state appears at `pull_dn` one edge after the fault, or one edge after `sd_below`. It also appears as gate enables that return before `sd_above` is seen, or fail to return two edges after it. The bench compares all three outputs every cycle against an independent cycle model, so any such divergence is reported in the cycle it reaches a port. It also measures handover gaps directly at the ports for each edge-timing case.

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int DT_W   = 10,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_hi,
  input  logic            cmd_lo_n,
  input  logic            fault,
  input  logic            sd_below,
  input  logic            sd_above,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            gate_hi,
  output logic            gate_lo,
  output logic            pull_dn
);

  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_WAIT} trip_st_t;

  logic [SYNC_N-1:0] hi_sync, lo_sync;
  logic              hi_q, lo_q;
  logic [DT_W-1:0]   off_cnt;
  trip_st_t          st;

  wire want_hi = hi_sync[SYNC_N-1] & lo_sync[SYNC_N-1];
  wire want_lo = ~hi_sync[SYNC_N-1] & ~lo_sync[SYNC_N-1];
  wire run_ok  = (st == ST_RUN) & ~sd_below & ~fault;
  wire dt_done = ~hi_q & ~lo_q & (off_cnt >= dead_cycles);

  assign gate_hi = hi_q & run_ok;
  assign gate_lo = lo_q & run_ok;
  assign pull_dn = (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sync <= '0;
      lo_sync <= '1;
    end else begin
      hi_sync <= {hi_sync[SYNC_N-2:0], cmd_hi};
      lo_sync <= {lo_sync[SYNC_N-2:0], cmd_lo_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      off_cnt <= '0;
    end else begin
      hi_q    <= run_ok & want_hi & (hi_q | dt_done);
      lo_q    <= run_ok & want_lo & (lo_q | dt_done);
      if (hi_q | lo_q)
        off_cnt <= '0;
      else if (off_cnt != CNT_MAX)
        off_cnt <= off_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st <= ST_RUN;
    else if (fault)
      st <= ST_HOLD;
    else if (st == ST_HOLD && sd_below)
      st <= ST_WAIT;
    else if (st == ST_WAIT && sd_above)
      st <= ST_RUN;
  end

  // R6
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R5
  hi_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(!gate_lo));

  // R5
  lo_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> $past(!gate_hi));

  // R8
  fault_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> pull_dn);

  // R8
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_dn && !sd_below) |=> pull_dn);

  // R9
  released_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_dn) |-> (!gate_hi && !gate_lo));

  // R7
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!gate_hi && !gate_lo));

endmodule

// File: tb/hb_gate_ctrl_bench.sv
module hb_gate_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DT_W  = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_hi = 0, cmd_lo_n = 1, fault = 0, sd_below = 0, sd_above = 1;
  logic [DT_W-1:0] dead_cycles = 2;
  logic gate_hi, gate_lo, pull_dn;

  int total = 0, bad = 0, cyc = 0;

  hb_gate_ctrl #(.DT_W(DT_W), .SYNC_N(2)) u_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo_n(cmd_lo_n),
    .fault(fault), .sd_below(sd_below), .sd_above(sd_above),
    .dead_cycles(dead_cycles), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .pull_dn(pull_dn));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // independent cycle model built from the requirements
  logic m_h1, m_h2, m_l1, m_l2, m_gh, m_gl;
  int   m_cnt;
  int   m_st;

  function automatic bit m_run();
    return (m_st == 0) && !sd_below && !fault;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h1 <= 0; m_h2 <= 0; m_l1 <= 1; m_l2 <= 1;
      m_gh <= 0; m_gl <= 0; m_cnt <= 0; m_st <= 0;
    end else begin
      cyc <= cyc + 1;
      m_h1 <= cmd_hi; m_h2 <= m_h1;
      m_l1 <= cmd_lo_n; m_l2 <= m_l1;
      m_gh <= m_run() && m_h2 && m_l2 && (m_gh || (!m_gl && m_cnt >= int'(dead_cycles)));
      m_gl <= m_run() && !m_h2 && !m_l2 && (m_gl || (!m_gh && m_cnt >= int'(dead_cycles)));
      m_cnt <= (m_gh || m_gl) ? 0 : ((m_cnt >= 1023) ? 1023 : m_cnt + 1);
      if (fault) m_st <= 1;
      else if (m_st == 1 && sd_below) m_st <= 2;
      else if (m_st == 2 && sd_above) m_st <= 0;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(!(gate_hi && gate_lo), "R6 exclusive", {gate_hi, gate_lo}, 0);
      chk(gate_hi == (m_gh && m_run()), "R1 model gate_hi", gate_hi, m_gh && m_run());
      chk(gate_lo == (m_gl && m_run()), "R1 model gate_lo", gate_lo, m_gl && m_run());
      chk(pull_dn == (m_st == 1), "R8 model pull_dn", pull_dn, m_st == 1);
    end
  end

  initial begin
    #(CLK_P * 150000);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R5: measure both-off cycles during a HIGH -> LOW handover
  task automatic gap_test(input int dt, input int n, input bit ovl);
    int gap = 0;
    int expv;
    bit seen_lo = 0;
    @(negedge clk);
    dead_cycles = dt[DT_W-1:0];
    cmd_hi = 1; cmd_lo_n = 1;
    for (int i = 0; i < 2000 && !gate_hi; i++) begin @(negedge clk); #1; end
    chk(gate_hi == 1, "R5 setup gate_hi", gate_hi, 1);
    for (int i = 0; i < dt + n + 20 && !seen_lo; i++) begin
      @(negedge clk);
      if (ovl) begin
        if (i == 0) cmd_lo_n = 0;
        if (i == n) cmd_hi = 0;
      end else begin
        if (i == 0) cmd_hi = 0;
        if (i == n) cmd_lo_n = 0;
      end
      #1;
      if (gate_lo) seen_lo = 1;
      else if (!gate_hi) gap++;
    end
    expv = (n > dt + 1) ? n : dt + 1;
    chk(seen_lo && gap == expv, $sformatf("R5 gap dt=%0d n=%0d ovl=%0d", dt, n, ovl), gap, expv);
  endtask

  int line;
  initial begin
    void'($urandom(32'd4242));
    #1;
    // R10
    chk(gate_hi == 0, "R10 reset gate_hi", gate_hi, 0);
    chk(gate_lo == 0, "R10 reset gate_lo", gate_lo, 0);
    chk(pull_dn == 0, "R10 reset pull_dn", pull_dn, 0);
    wait_cyc(3);
    rst_n = 1;
    // R4 idle
    wait_cyc(8); #1;
    chk(!gate_hi && !gate_lo, "R4 idle both off", {gate_hi, gate_lo}, 0);
    // R1 latency: hi request shows on third edge
    @(negedge clk); cmd_hi = 1; #1;
    chk(gate_hi == 0, "R1 latency edge0", gate_hi, 0);
    @(negedge clk); #1; chk(gate_hi == 0, "R1 latency edge1", gate_hi, 0);
    @(negedge clk); #1; chk(gate_hi == 0, "R1 latency edge2", gate_hi, 0);
    @(negedge clk); #1; chk(gate_hi == 1, "R1 latency edge3", gate_hi, 1);
    // R2 shutdown line low
    @(negedge clk); sd_below = 1; sd_above = 0; #1;
    chk(gate_hi == 0, "R2 sd_below same cycle", gate_hi, 0);
    wait_cyc(3); #1;
    chk(!gate_hi && !gate_lo && !pull_dn, "R2 held off", {gate_hi, gate_lo, pull_dn}, 0);
    @(negedge clk); sd_below = 0; sd_above = 1;
    wait_cyc(6); #1;
    chk(gate_hi == 1, "R2 resume after line high", gate_hi, 1);
    // R3 overlap
    @(negedge clk); cmd_lo_n = 0;
    wait_cyc(5); #1;
    chk(!gate_hi && !gate_lo, "R3 overlap both off", {gate_hi, gate_lo}, 0);
    // R1 low side
    @(negedge clk); cmd_hi = 0;
    wait_cyc(8); #1;
    chk(gate_lo == 1 && gate_hi == 0, "R1 low side on", {gate_hi, gate_lo}, 1);
    // R4 again from low side
    @(negedge clk); cmd_lo_n = 1;
    wait_cyc(5); #1;
    chk(!gate_hi && !gate_lo, "R4 idle after low", {gate_hi, gate_lo}, 0);

    gap_test(2, 0, 0);
    gap_test(2, 1, 0);
    gap_test(2, 5, 0);
    gap_test(5, 3, 1);
    gap_test(0, 0, 0);
    gap_test(0, 4, 1);
    gap_test(7, 12, 0);
    gap_test(1023, 0, 0);

    // R7/R8/R9 fault sequence
    @(negedge clk); dead_cycles = 1; cmd_hi = 1; cmd_lo_n = 1;
    wait_cyc(8); #1;
    chk(gate_hi == 1, "R7 setup", gate_hi, 1);
    @(negedge clk); fault = 1; #1;
    chk(gate_hi == 0, "R7 same cycle off", gate_hi, 0);
    @(negedge clk); fault = 0; #1;
    chk(pull_dn == 1, "R8 pull engaged", pull_dn, 1);
    wait_cyc(5); #1;
    chk(pull_dn == 1 && gate_hi == 0, "R8 pull held", pull_dn, 1);
    @(negedge clk); sd_above = 0; sd_below = 1; #1;
    chk(pull_dn == 1, "R8 pull before edge", pull_dn, 1);
    @(negedge clk); #1;
    chk(pull_dn == 0, "R8 pull released", pull_dn, 0);
    @(negedge clk); sd_below = 0;
    wait_cyc(4); #1;
    chk(gate_hi == 0, "R9 off before upper threshold", gate_hi, 0);
    @(negedge clk); sd_above = 1; #1;
    chk(gate_hi == 0, "R9 resume edge0", gate_hi, 0);
    @(negedge clk); #1; chk(gate_hi == 0, "R9 resume edge1", gate_hi, 0);
    @(negedge clk); #1; chk(gate_hi == 1, "R9 resume edge2", gate_hi, 1);

    // random phase, checked by the cycle model every cycle
    line = 2;
    for (int seg = 0; seg < 4; seg++) begin
      @(negedge clk);
      dead_cycles = (seg == 3) ? DT_W'($urandom_range(0, 20)) : DT_W'(seg * seg);
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        if ($urandom_range(0, 9) == 0) cmd_hi = ~cmd_hi;
        if ($urandom_range(0, 9) == 0) cmd_lo_n = ~cmd_lo_n;
        fault = ($urandom_range(0, 199) == 0);
        if (pull_dn) begin
          if (line > 0 && $urandom_range(0, 2) == 0) line--;
        end else if ($urandom_range(0, 299) == 0) line = 0;
        else if (line < 2 && $urandom_range(0, 5) == 0) line++;
        sd_below = (line == 0);
        sd_above = (line == 2);
      end
    end
    fault = 0;
    wait_cyc(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule